// File: doc/BRIEF.md
# Latching Heartbeat Safety Watchdog

This block guards a radio transmitter against loss of its controlling software. The software sends a one-cycle heartbeat pulse at regular intervals. The block counts clock cycles since the last heartbeat. If that count reaches the configured timeout, it raises a kill signal that shuts down the RF output. The kill signal then stays latched. Further heartbeats do not release it. Only an explicit operator force-reset, or the chip reset, clears it. The design is fail-safe: it never recovers on its own.

A warning flag rises ahead of the timeout. It gives the software a chance to notice that it is late. A whole-seconds countdown is provided for status reporting. An enable input switches the whole function off.

The clock rate, the timeout and the warning point are parameters, given in seconds. Setting the clock rate to one cycle per second gives a scaled-down instance with the same behaviour.

Top module: `hbwd_top`

## Requirements
- R1: While `rstN` is low, the elapsed count clears to zero and `triggered` and `warning` clear to zero. After release with `enable` high, `timeRemaining` reads TIMEOUT_SEC.
- R2: While enabled, not triggered, and with no heartbeat, the elapsed count rises by exactly one per clock. `triggered` rises on the clock edge on which the count reaches TIMEOUT_CYCLES = CLK_FREQ × TIMEOUT_SEC, and never before. The count never exceeds that value.
- R3: A heartbeat (`heartbeat` high on a clock edge) while not triggered sets the elapsed count to zero and drops `warning`.
- R4: `warning` is high exactly when the elapsed count is at least WARNING_CYCLES = CLK_FREQ × WARNING_SEC. `triggered` high always implies `warning` high.
- R5: Once `triggered` is high, it stays high, and heartbeats have no effect on any output, until `forceReset` or reset.
- R6: `forceReset` high on a clock edge clears the count, `triggered` and `warning`. It takes priority over `heartbeat` and over a latched trigger.
- R7: While `enable` is low, `timeRemaining` reads zero. On every clock edge with `enable` low, the count, `triggered` and `warning` clear. After re-enabling, counting starts from zero.
- R8: While enabled, `timeRemaining` equals TIMEOUT_SEC − floor(count / CLK_FREQ). It is zero whenever triggered, and it never increases from one clock to the next unless a heartbeat, force-reset or enable change intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Function enable; low holds everything cleared |
| heartbeat | input | 1 | Liveness pulse from control software |
| forceReset | input | 1 | Operator clear, including a latched trigger |
| triggered | output | 1 | Latched RF kill |
| warning | output | 1 | Pre-timeout warning |
| timeRemaining | output | $clog2(TIMEOUT_SEC+1) | Whole seconds left before the trigger |

## Verification
The hardest situations to reach are at the edges of the timing window.

The first is a heartbeat that arrives on the very last cycle before the timeout. The second is a force-reset that coincides with a heartbeat while the trigger is latched. Random heartbeats rarely land on those exact cycles.

Directed sequences therefore idle the block to one cycle short of the timeout and then inject the pulse there. They also drive both clears together on a latched trigger.

A scaled-down clock parameter keeps the timeout at twenty cycles. As a result, the random phase, with sparse heartbeats, crosses the warning point and reaches the trigger many times.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero the elapsed count, reload seconds
    logic advance;  // one more cycle without heartbeat
  } hbwd_strobe_t;
endpackage

// File: rtl/hbwd_datapath.sv
module hbwd_datapath
  import hbwd_pkg::*;
#(
  parameter int unsigned CLK_FREQ    = 125000000,
  parameter int unsigned TIMEOUT_SEC = 5,
  parameter int unsigned WARNING_SEC = 4,
  localparam int unsigned TIMEOUT_CYCLES = CLK_FREQ * TIMEOUT_SEC,
  localparam int unsigned WARNING_CYCLES = CLK_FREQ * WARNING_SEC,
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1),
  localparam int unsigned SUB_W = (CLK_FREQ > 1) ? $clog2(CLK_FREQ) : 1,
  localparam int unsigned SEC_W = $clog2(TIMEOUT_SEC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hbwd_strobe_t     strobe,
  output logic             lastStep,
  output logic             warnStep,
  output logic [SEC_W-1:0] secLeft
);
  logic [CNT_W-1:0] cycleCnt;
  logic [SUB_W-1:0] subCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      cycleCnt <= '0;
      subCnt   <= '0;
      secLeft  <= SEC_W'(TIMEOUT_SEC);
    end else if (strobe.advance && cycleCnt != CNT_W'(TIMEOUT_CYCLES)) begin
      cycleCnt <= cycleCnt + 1'b1;
      if (subCnt == SUB_W'(CLK_FREQ - 1)) begin
        subCnt <= '0;
        if (secLeft != '0) secLeft <= secLeft - 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  // Conditions on the count that the next advance will produce
  assign lastStep = (cycleCnt == CNT_W'(TIMEOUT_CYCLES - 1));
  assign warnStep = (cycleCnt >= CNT_W'(WARNING_CYCLES - 1));
endmodule

// File: rtl/hbwd_ctrl.sv
module hbwd_ctrl
  import hbwd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         heartbeat,
  input  logic         forceReset,
  input  logic         lastStep,
  input  logic         warnStep,
  output hbwd_strobe_t strobe,
  output logic         triggered,
  output logic         warning
);
  logic wipe;
  assign wipe = forceReset | ~enable;

  always_comb begin
    strobe.clear   = wipe | (heartbeat & ~triggered);
    strobe.advance = ~wipe & ~triggered & ~heartbeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      triggered <= 1'b0;
      warning   <= 1'b0;
    end else if (strobe.advance) begin
      if (lastStep) triggered <= 1'b1;
      if (warnStep) warning   <= 1'b1;
    end
  end
endmodule

// File: rtl/hbwd_top.sv
module hbwd_top
  import hbwd_pkg::*;
#(
  parameter int unsigned CLK_FREQ    = 125000000,
  parameter int unsigned TIMEOUT_SEC = 5,
  parameter int unsigned WARNING_SEC = 4,
  localparam int unsigned SEC_W = $clog2(TIMEOUT_SEC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             heartbeat,
  input  logic             forceReset,
  output logic             triggered,
  output logic             warning,
  output logic [SEC_W-1:0] timeRemaining
);
  hbwd_strobe_t     strobe;
  logic             lastStep;
  logic             warnStep;
  logic [SEC_W-1:0] secLeft;

  hbwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .heartbeat(heartbeat),
    .forceReset(forceReset), .lastStep(lastStep), .warnStep(warnStep),
    .strobe(strobe), .triggered(triggered), .warning(warning)
  );

  hbwd_datapath #(
    .CLK_FREQ(CLK_FREQ), .TIMEOUT_SEC(TIMEOUT_SEC), .WARNING_SEC(WARNING_SEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lastStep(lastStep), .warnStep(warnStep), .secLeft(secLeft)
  );

  assign timeRemaining = enable ? secLeft : '0;
endmodule

// File: rtl/hbwd_props.sv
module hbwd_props #(
  parameter int unsigned TR_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            heartbeat,
  input logic            forceReset,
  input logic            triggered,
  input logic            warning,
  input logic [TR_W-1:0] timeRemaining
);
  a_r4_trig_implies_warn: assert property (@(posedge clk) disable iff (!rstN)
    triggered |-> warning);

  a_r5_trigger_latched: assert property (@(posedge clk) disable iff (!rstN)
    (triggered && enable && !forceReset) |=> triggered);

  a_r6_force_clears: assert property (@(posedge clk) disable iff (!rstN)
    forceReset |=> (!triggered && !warning));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!triggered && !warning));

  a_r7_disable_zero_time: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (timeRemaining == '0));

  a_r8_zero_when_triggered: assert property (@(posedge clk) disable iff (!rstN)
    triggered |-> (timeRemaining == '0));

  a_r8_non_increasing: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !heartbeat && !forceReset) |=> (timeRemaining <= $past(timeRemaining)));
endmodule

bind hbwd_top hbwd_props #(.TR_W(SEC_W)) u_props (
  .clk(clk), .rstN(rstN), .enable(enable), .heartbeat(heartbeat),
  .forceReset(forceReset), .triggered(triggered), .warning(warning),
  .timeRemaining(timeRemaining)
);

// File: tb/sim_hbwd_top.sv
module sim_hbwd_top;
  localparam int CLK_PERIOD = 10;
  localparam int F  = 4;
  localparam int TS = 5;
  localparam int WS = 3;
  localparam int T  = F * TS;   // 20
  localparam int W  = F * WS;   // 12
  localparam int TRW = $clog2(TS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic heartbeat = 1'b0;
  logic forceReset = 1'b0;
  logic triggered, warning;
  logic [TRW-1:0] timeRemaining;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Reference state derived from the requirements
  int mC = 0;
  bit mT = 1'b0;
  bit mW = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbwd_top #(.CLK_FREQ(F), .TIMEOUT_SEC(TS), .WARNING_SEC(WS)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .heartbeat(heartbeat),
    .forceReset(forceReset), .triggered(triggered), .warning(warning),
    .timeRemaining(timeRemaining)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN || forceReset || !enable) begin
      mC <= 0; mT <= 1'b0; mW <= 1'b0;
    end else if (mT) begin
      mC <= mC;
    end else if (heartbeat) begin
      mC <= 0; mW <= 1'b0;
    end else begin
      mC <= (mC < T) ? mC + 1 : mC;
      mT <= ((mC + 1) >= T);
      mW <= ((mC + 1) >= W);
    end
  end

  function automatic int expRemain(int c, bit en);
    if (!en) return 0;
    return TS - c / F;
  endfunction

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    expect_eq(tag, "triggered", int'(triggered), int'(mT));
    expect_eq(tag, "warning", int'(warning), int'(mW));
    expect_eq(tag, "timeRemaining", int'(timeRemaining), expRemain(mC, enable));
  endtask

  task automatic step(bit en, bit hb, bit fr, string tag);
    enable = en; heartbeat = hb; forceReset = fr;
    @(negedge clk);
    check_model(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    enable = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    expect_eq("R1", "triggered", int'(triggered), 0);
    expect_eq("R1", "warning", int'(warning), 0);
    expect_eq("R1", "timeRemaining", int'(timeRemaining), TS);

    // R2 / R4 / R8: walk up to the warning point and the timeout
    idle(W - 1, "R2");
    expect_eq("R4", "warning below threshold", int'(warning), 0);
    idle(1, "R4");
    expect_eq("R4", "warning at threshold", int'(warning), 1);
    expect_eq("R8", "seconds at threshold", int'(timeRemaining), TS - WS);
    idle(T - W - 1, "R2");
    expect_eq("R2", "no early trigger", int'(triggered), 0);
    idle(1, "R2");
    expect_eq("R2", "trigger at timeout", int'(triggered), 1);
    expect_eq("R8", "zero at trigger", int'(timeRemaining), 0);

    // R5: heartbeats ignored once latched
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");
    expect_eq("R5", "still latched", int'(triggered), 1);

    // R6: force-reset together with heartbeat on a latched trigger
    step(1'b1, 1'b1, 1'b1, "R6");
    expect_eq("R6", "trigger cleared", int'(triggered), 0);
    expect_eq("R6", "warning cleared", int'(warning), 0);
    expect_eq("R6", "seconds reloaded", int'(timeRemaining), TS);

    // R3: heartbeat on the last cycle before timeout
    idle(T - 1, "R3");
    step(1'b1, 1'b1, 1'b0, "R3");
    expect_eq("R3", "no trigger", int'(triggered), 0);
    expect_eq("R3", "warning dropped", int'(warning), 0);
    idle(1, "R3");
    expect_eq("R3", "count restarted", int'(timeRemaining), TS);

    // R7: disable mid-count, then re-enable
    idle(W + 2, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    expect_eq("R7", "zero time while off", int'(timeRemaining), 0);
    expect_eq("R7", "warning off", int'(warning), 0);
    idle(W - 1, "R7");
    expect_eq("R7", "restart from zero", int'(warning), 0);

    // Random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      bit en, hb, fr;
      en = (($urandom % 60) != 0);
      hb = (($urandom % 28) == 0);
      fr = (($urandom % 90) == 0);
      step(en, hb, fr, "R8");
    end
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule